// File: doc/BRIEF.md
# Delayed Read Request Queue

This block keeps the delayed read requests that one direction of a bus bridge has accepted but not yet answered. An initiator read that cannot be served at once is entered at the tail as a pending request. The target side later reports that the oldest pending read has finished. When the initiator repeats the same read, the block compares it against every stored entry in the same cycle and answers with exactly one result: the data may be delivered now, the request is already queued, the request was accepted as a new entry, or the queue is full and the request was refused.

Entries leave only from the head. There are three ways out. The repeating initiator takes the data while ordering against posted writes allows it, which is signalled by a single input flag. A discard timer can expire after the completed head has waited too long. An explicit discard strobe can remove it. Memory read, memory read line and memory read multiple are one command for matching. I/O and configuration reads must match exactly.

Top module: `dly_rd_queue`

## Requirements
- R1: After reset the queue is empty: `head_valid` is 0, every position of `entry_state` reads EMPTY and no response flag is set.
- R2: A request (`req_valid`=1) that matches no stored entry while fewer than DEPTH entries are held raises `rsp_post` in the same cycle. It is appended at the tail in state PENDING, which is visible from the next cycle on.
- R3: A request that matches a stored entry (equal address, equivalent command) raises `rsp_dup` and creates no new entry, unless it qualifies as a hit under R6.
- R4: The memory read commands 4'b0110, 4'b1110 and 4'b1100 are equivalent when matching.
- R5: Any other read command, for example I/O read 4'b0010 or configuration read 4'b1010, matches only an entry holding the identical code.
- R6: `rsp_hit` is raised only when the matching entry is the head, that entry is COMPLETE and `order_ok` is 1. The head then retires at that clock edge.
- R7: A non-matching request while DEPTH entries are held raises `rsp_full` and is not stored.
- R8: `cpl_valid` turns the oldest PENDING entry into COMPLETE at the clock edge. It has no effect when no entry is PENDING.
- R9: A head that has been COMPLETE for TMO_CYC consecutive cycles without being delivered is removed at the end of the TMO_CYC-th cycle.
- R10: `disc_req` removes the head when the head is COMPLETE. It has no effect on a PENDING head.
- R11: `entry_state` lists the entries in queue order, with the head in bits [1:0] and each next position two bits higher. The encoding is 0 EMPTY, 1 PENDING and 2 COMPLETE, and positions beyond the number of held entries read EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Initiator read request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | 4 | Request bus command |
| order_ok | input | 1 | Ordering against posted writes is satisfied |
| cpl_valid | input | 1 | Target side finished the oldest pending read |
| disc_req | input | 1 | Discard a completed head entry |
| rsp_hit | output | 1 | Data may be delivered; the head retires |
| rsp_dup | output | 1 | Request is already queued |
| rsp_post | output | 1 | Request accepted as a new entry |
| rsp_full | output | 1 | Request refused because the queue is full |
| head_valid | output | 1 | Queue holds at least one entry |
| head_addr | output | ADDR_W | Address of the head entry |
| head_cmd | output | 4 | Command of the head entry as it was posted |
| head_state | output | 2 | State of the head entry |
| entry_state | output | 2*DEPTH | Per-position state in queue order |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=32 and TMO_CYC=12. The short timeout lets the discard timer expire many times inside the random phase, often in the same cycle as a completion, a post or a hit. Drawing addresses from a pool of five values keeps the four-entry queue full much of the time and makes duplicate and alias matches frequent. Directed sequences pin down the exact cycle of the timeout removal, discard on a pending head, and the command aliasing rules.

// File: rtl/drq_pkg.sv
package drq_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_PEND  = 2'd1,
        SLOT_DONE  = 2'd2
    } slot_st_e;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_MEM_RM = 4'b1100;
    localparam logic [3:0] CMD_MEM_RL = 4'b1110;

    // Folds the memory read variants onto one key; all others stay exact.
    function automatic logic [3:0] cmd_key(input logic [3:0] cmd);
        if (cmd == CMD_MEM_RL || cmd == CMD_MEM_RM)
            return CMD_MEM_RD;
        return cmd;
    endfunction

endpackage

// File: rtl/drq_match.sv
module drq_match
    import drq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32
) (
    input  logic [DEPTH-1:0]             slot_live,
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic [DEPTH-1:0][3:0]        slot_cmd,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [3:0]                   req_cmd,
    output logic [DEPTH-1:0]             hit_vec
);

    logic [3:0] req_key;
    assign req_key = cmd_key(req_cmd);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = slot_live[g]
                         && (slot_addr[g] == req_addr)
                         && (cmd_key(slot_cmd[g]) == req_key);
    end

endmodule

// File: rtl/drq_timer.sv
module drq_timer #(
    parameter int TMO_CYC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic head_done,
    input  logic pop,
    output logic expire
);

    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign expire = head_done && (cnt_q == CW'(TMO_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || pop || !head_done)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R9
    tmr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(TMO_CYC));

    // R9
    tmr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        pop |=> (cnt_q == '0));

endmodule

// File: rtl/drq_store.sv
module drq_store
    import drq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [ADDR_W-1:0]            push_addr,
    input  logic [3:0]                   push_cmd,
    input  logic                         pop,
    input  logic                         cpl,
    output logic [DEPTH-1:0]             slot_live,
    output logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    output logic [DEPTH-1:0][3:0]        slot_cmd,
    output logic [$clog2(DEPTH)-1:0]     rd_ptr,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [1:0]                   head_st,
    output logic [DEPTH-1:0][1:0]        pos_state
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    slot_st_e             st_q   [DEPTH];
    logic [PTR_W-1:0]     rd_q, wr_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [DEPTH-1:0]     cpl_sel;
    logic                 found;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_live
        assign slot_live[g] = (st_q[g] != SLOT_EMPTY);
    end

    // Walk the ring from the head: pick the oldest pending slot and
    // lay out the states by queue position.
    always_comb begin
        cpl_sel   = '0;
        found     = 1'b0;
        pos_state = '0;
        for (int p = 0; p < DEPTH; p++) begin
            int s;
            s = int'(rd_q) + p;
            if (s >= DEPTH) s = s - DEPTH;
            pos_state[p] = st_q[PTR_W'(s)];
            if (!found && st_q[PTR_W'(s)] == SLOT_PEND) begin
                cpl_sel[PTR_W'(s)] = 1'b1;
                found              = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]      <= SLOT_EMPTY;
                slot_addr[i] <= '0;
                slot_cmd[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (cpl && cpl_sel[i]) st_q[i] <= SLOT_DONE;
            if (pop) begin
                st_q[rd_q] <= SLOT_EMPTY;
                rd_q       <= nxt(rd_q);
            end
            if (push) begin
                st_q[wr_q]      <= SLOT_PEND;
                slot_addr[wr_q] <= push_addr;
                slot_cmd[wr_q]  <= push_cmd;
                wr_q            <= nxt(wr_q);
            end
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign rd_ptr  = rd_q;
    assign count   = cnt_q;
    assign head_st = st_q[rd_q];

    // R7
    store_occ_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CNT_W'(DEPTH)));

    // R6
    pop_done_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> (st_q[rd_q] == SLOT_DONE));

endmodule

// File: rtl/dly_rd_queue.sv
module dly_rd_queue
    import drq_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = 32,
    parameter int TMO_CYC = 32768
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_cmd,
    input  logic                 order_ok,
    input  logic                 cpl_valid,
    input  logic                 disc_req,
    output logic                 rsp_hit,
    output logic                 rsp_dup,
    output logic                 rsp_post,
    output logic                 rsp_full,
    output logic                 head_valid,
    output logic [ADDR_W-1:0]    head_addr,
    output logic [3:0]           head_cmd,
    output logic [1:0]           head_state,
    output logic [2*DEPTH-1:0]   entry_state
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]             slot_live, hit_vec;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][3:0]        slot_cmd;
    logic [DEPTH-1:0][1:0]        pos_state;
    logic [PTR_W-1:0]             rd_ptr;
    logic [CNT_W-1:0]             count;
    logic [1:0]                   head_st;
    logic                         any_match, is_full, head_done;
    logic                         tmo_exp, pop;

    drq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
        .slot_live (slot_live),
        .slot_addr (slot_addr),
        .slot_cmd  (slot_cmd),
        .req_addr  (req_addr),
        .req_cmd   (req_cmd),
        .hit_vec   (hit_vec)
    );

    drq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (rsp_post),
        .push_addr (req_addr),
        .push_cmd  (req_cmd),
        .pop       (pop),
        .cpl       (cpl_valid),
        .slot_live (slot_live),
        .slot_addr (slot_addr),
        .slot_cmd  (slot_cmd),
        .rd_ptr    (rd_ptr),
        .count     (count),
        .head_st   (head_st),
        .pos_state (pos_state)
    );

    drq_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .head_done (head_done),
        .pop       (pop),
        .expire    (tmo_exp)
    );

    assign any_match  = |hit_vec;
    assign is_full    = (count == CNT_W'(DEPTH));
    assign head_valid = (count != '0);
    assign head_done  = head_valid && (head_st == SLOT_DONE);

    assign rsp_hit  = req_valid && hit_vec[rd_ptr] && head_done && order_ok;
    assign rsp_dup  = req_valid && any_match && !rsp_hit;
    assign rsp_post = req_valid && !any_match && !is_full;
    assign rsp_full = req_valid && !any_match && is_full;

    assign pop = rsp_hit || (head_done && (tmo_exp || disc_req));

    assign head_addr   = slot_addr[rd_ptr];
    assign head_cmd    = slot_cmd[rd_ptr];
    assign head_state  = head_st;
    assign entry_state = pos_state;

    // R2
    resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_hit, rsp_dup, rsp_post, rsp_full}));

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R6
    hit_retire_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |=> (count == $past(count) - 1'b1));

    // R2
    post_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_post && !pop) |=> (count == $past(count) + 1'b1));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_full && !pop) |=> (count == CNT_W'(DEPTH)));

endmodule

// File: tb/dly_rd_queue_tb.sv
`timescale 1ns/1ps
module dly_rd_queue_tb_top;

    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int TMO   = 12;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid, order_ok, cpl_valid, disc_req;
    logic [AW-1:0]   req_addr;
    logic [3:0]      req_cmd;
    logic            rsp_hit, rsp_dup, rsp_post, rsp_full, head_valid;
    logic [AW-1:0]   head_addr;
    logic [3:0]      head_cmd;
    logic [1:0]      head_state;
    logic [2*DEPTH-1:0] entry_state;

    int tests = 0;
    int fails = 0;

    logic [AW-1:0] m_addr[$];
    logic [3:0]    m_cmd[$];
    logic [1:0]    m_st[$];
    int            m_tmr;

    always #4 clk = ~clk;

    dly_rd_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .order_ok(order_ok), .cpl_valid(cpl_valid),
        .disc_req(disc_req), .rsp_hit(rsp_hit), .rsp_dup(rsp_dup),
        .rsp_post(rsp_post), .rsp_full(rsp_full), .head_valid(head_valid),
        .head_addr(head_addr), .head_cmd(head_cmd), .head_state(head_state),
        .entry_state(entry_state)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_mem(input logic [3:0] c);
        return c == 4'b0110 || c == 4'b1110 || c == 4'b1100;
    endfunction

    function automatic bit same_req(input logic [AW-1:0] a1, input logic [3:0] c1,
                                    input logic [AW-1:0] a2, input logic [3:0] c2);
        return (a1 == a2) && ((c1 == c2) || (is_mem(c1) && is_mem(c2)));
    endfunction

    function automatic logic [2*DEPTH-1:0] model_es();
        logic [2*DEPTH-1:0] r = '0;
        for (int i = 0; i < m_st.size(); i++) r[2*i +: 2] = m_st[i];
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 0; req_addr = '0; req_cmd = '0;
        order_ok = 0; cpl_valid = 0; disc_req = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_addr.delete(); m_cmd.delete(); m_st.delete(); m_tmr = 0;
    endtask

    // One cycle: drive at negedge, check before the next rising edge, advance model.
    task automatic cyc(input bit v, input logic [AW-1:0] a, input logic [3:0] c,
                       input bit ord, input bit cpl, input bit dsc);
        int  mi = -1;
        bit  eh, ed, ep, ef, hd, pop;
        string tag;
        @(negedge clk);
        req_valid = v; req_addr = a; req_cmd = c;
        order_ok = ord; cpl_valid = cpl; disc_req = dsc;
        #1;
        for (int i = 0; i < m_addr.size(); i++)
            if (same_req(m_addr[i], m_cmd[i], a, c)) mi = i;
        eh = v && mi == 0 && m_st[0] == 2'd2 && ord;
        ed = v && mi >= 0 && !eh;
        ep = v && mi < 0 && m_addr.size() < DEPTH;
        ef = v && mi < 0 && m_addr.size() == DEPTH;
        tag = eh ? "R6" : ed ? "R3" : ef ? "R7" : "R2";
        chk(tag, {rsp_hit, rsp_dup, rsp_post, rsp_full}, {eh, ed, ep, ef});
        chk("R11", entry_state, model_es());
        if (m_addr.size() > 0)
            chk("R8", {head_valid, head_state, head_cmd, head_addr},
                      {1'b1, m_st[0], m_cmd[0], m_addr[0]});
        else
            chk("R1", head_valid, 1'b0);
        hd  = m_st.size() > 0 && m_st[0] == 2'd2;
        pop = eh || (hd && (m_tmr == TMO - 1 || dsc));
        if (cpl)
            for (int i = 0; i < m_st.size(); i++)
                if (m_st[i] == 2'd1) begin m_st[i] = 2'd2; break; end
        if (pop) begin void'(m_addr.pop_front()); void'(m_cmd.pop_front()); void'(m_st.pop_front()); end
        if (ep) begin m_addr.push_back(a); m_cmd.push_back(c); m_st.push_back(2'd1); end
        m_tmr = (pop || !hd) ? 0 : m_tmr + 1;
    endtask

    task automatic idle(); cyc(0, '0, 4'h0, 0, 0, 0); endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] cmds [5] = '{4'b0010, 4'b0110, 4'b1010, 4'b1100, 4'b1110};
        void'($urandom(1234));
        rst = 1'b1;
        do_reset();
        #1;
        // R1: reset state
        chk("R1", {head_valid, entry_state, rsp_hit, rsp_dup, rsp_post, rsp_full}, '0);

        // R8: completion with nothing pending is ignored
        cyc(0, '0, 4'h0, 0, 1, 0);
        idle();
        chk("R8", entry_state, '0);

        // R7: fill, then refuse a fifth distinct request
        for (int i = 0; i < DEPTH; i++) cyc(1, 32'h1000 + i * 16, 4'b0110, 0, 0, 0);
        cyc(1, 32'h2000, 4'b0110, 0, 0, 0);
        chk("R7", {rsp_full, rsp_post}, 2'b10);
        idle();
        chk("R7", head_valid, 1'b1);
        chk("R11", entry_state, 8'b01_01_01_01);

        // R4: memory read variants alias
        do_reset();
        cyc(1, 32'h3000, 4'b0110, 1, 0, 0);
        cyc(1, 32'h3000, 4'b1110, 1, 0, 0);
        chk("R4", rsp_dup, 1'b1);
        cyc(1, 32'h3000, 4'b1100, 1, 1, 0);
        chk("R4", rsp_dup, 1'b1);
        cyc(1, 32'h3000, 4'b1110, 0, 0, 0);
        chk("R6", {rsp_hit, rsp_dup}, 2'b01);
        cyc(1, 32'h3000, 4'b1110, 1, 0, 0);
        chk("R4", rsp_hit, 1'b1);
        idle();
        chk("R6", head_valid, 1'b0);

        // R5: I/O and configuration reads match exactly
        cyc(1, 32'h4000, 4'b0010, 1, 0, 0);
        cyc(1, 32'h4000, 4'b1010, 1, 0, 0);
        chk("R5", rsp_post, 1'b1);
        cyc(1, 32'h4000, 4'b0110, 1, 0, 0);
        chk("R5", rsp_post, 1'b1);
        cyc(1, 32'h4000, 4'b0010, 1, 0, 0);
        chk("R5", rsp_dup, 1'b1);

        // R10: discard ignored on a pending head, honoured on a complete one
        do_reset();
        cyc(1, 32'h5000, 4'b0010, 0, 0, 0);
        cyc(0, '0, 4'h0, 0, 0, 1);
        idle();
        chk("R10", {head_valid, head_state}, 3'b1_01);
        cyc(0, '0, 4'h0, 0, 1, 0);
        cyc(0, '0, 4'h0, 0, 0, 1);
        idle();
        chk("R10", head_valid, 1'b0);

        // R9: completed head expires after exactly TMO cycles
        cyc(1, 32'h6000, 4'b0110, 0, 0, 0);
        cyc(0, '0, 4'h0, 0, 1, 0);
        for (int i = 0; i < TMO; i++) idle();
        chk("R9", {head_valid, head_state}, 3'b1_10);
        idle();
        chk("R9", head_valid, 1'b0);

        // Random phase
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] a;
            logic [3:0]    c;
            a = 32'h100 * (1 + $urandom_range(0, 4));
            c = cmds[$urandom_range(0, 4)];
            cyc($urandom_range(0, 99) < 60, a, c, $urandom_range(0, 99) < 70,
                $urandom_range(0, 99) < 30, $urandom_range(0, 99) < 4);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule